// File: doc/BRIEF.md
# Stacked and Rotating Register Remapper

This block sits in the decode path of a processor whose general register file has 128 entries. It turns logical register numbers from two source operands and one destination operand into physical register-file indices. The lowest 32 numbers always name the same 32 physical registers. Numbers from 32 upward address the current procedure's frame. That frame is a window into a 96-entry circular stacked area, placed by a frame base.

The current frame marker holds the frame base, the frame size, the local count, the rotating-region size and the rotating base. Software sets the size fields with an allocate pulse. A call pulse opens a new frame that starts just past the caller's locals, so the caller's outgoing registers become the callee's first registers. A return pulse restores the caller's marker from an internal stack of saved markers. A rotate pulse, issued on each software-pipelined loop branch, shifts the rotating region at the bottom of the frame by one register.

Spilling frames to memory is not done here. The block only raises a flag when the frames in use need more than the stacked area holds. Translation is purely combinational, so the operand ports carry no handshake. Each result belongs to the logical number presented in the same cycle and can never be held off. The control pulses are plain single-cycle strobes.

Top module: `remap_top`

## Requirements
- R1: Logical numbers 0 to 31 map to the same physical number, with the bad flag low, whatever the frame state.
- R2: For a logical number L of 32 or more, let i = L − 32. If i is below the frame size and outside the rotating region, the physical index is 32 + ((base + i) mod 96).
- R3: A logical number with i at or above the frame size sets the port's bad flag and drives physical index 0.
- R4: An allocate pulse sets size, locals and rotating size from its three fields and clears the rotating base. The pulse is ignored when size exceeds 96, or when locals or rotating size exceed size.
- R5: For i below the rotating size R, i is first replaced by (i + rotating base) mod R. A rotate pulse changes the rotating base to (rotating base − 1) mod R. A rotate pulse has no effect when R is 0.
- R6: A call pulse saves the marker. It then sets base to (base + locals) mod 96 and size to size − locals, and clears locals, rotating size and rotating base. A call is ignored when 8 markers are already saved.
- R7: A return pulse restores the most recently saved marker, all five fields. A return with no saved marker is ignored.
- R8: The overflow output is high exactly when the sum of the locals of all saved markers plus the current frame size exceeds 96.
- R9: Reset leaves base, size, locals and rotating fields at 0, with no saved marker. When pulses coincide, only one acts, in the order call, return, allocate, rotate. A pulse that is ignored under its own rule still blocks the lower ones.
- R10: The two read ports and the write port translate by identical rules, so equal logical numbers give equal results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd0_log | input | 7 | Logical number, first source operand |
| rd0_phys | output | 7 | Physical index, first source operand |
| rd0_bad | output | 1 | First source is outside the frame |
| rd1_log | input | 7 | Logical number, second source operand |
| rd1_phys | output | 7 | Physical index, second source operand |
| rd1_bad | output | 1 | Second source is outside the frame |
| wr_log | input | 7 | Logical number, destination operand |
| wr_phys | output | 7 | Physical index, destination operand |
| wr_bad | output | 1 | Destination is outside the frame |
| call_i | input | 1 | Open a new frame |
| ret_i | input | 1 | Restore the caller's frame |
| alloc_i | input | 1 | Load the frame size fields |
| alloc_size | input | 7 | Frame size for allocate |
| alloc_locals | input | 7 | Local count for allocate |
| alloc_rot | input | 7 | Rotating-region size for allocate |
| rotate_i | input | 1 | Shift the rotating region by one |
| overflow_o | output | 1 | Frames in use exceed the stacked area |

## Verification
Any wrong marker field shows up in the next cycle as a wrong physical index or a wrong bad flag, for any operand that falls in the affected part of the frame. A bad size shows at the frame edge, a bad base at every stacked number, and a bad rotating base only inside the rotating region. A corrupted saved marker stays hidden until the matching return. A wrong locals tally likewise stays hidden until the overflow boundary is reached. The directed scenarios therefore probe the frame edges, wrap across the top of the stacked area, and return after nested calls.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int FW = 7;

  typedef struct packed {
    logic [FW-1:0] base;
    logic [FW-1:0] size;
    logic [FW-1:0] locals;
    logic [FW-1:0] rsize;
    logic [FW-1:0] rbase;
  } marker_t;
endpackage

// File: rtl/remap_xlate.sv
module remap_xlate #(
  parameter int FIX_REGS = 32,
  parameter int STK_REGS = 96,
  parameter int LW       = 7,
  parameter int FW       = 7
) (
  input  logic [LW-1:0] log_i,
  input  logic [FW-1:0] base_i,
  input  logic [FW-1:0] size_i,
  input  logic [FW-1:0] rsize_i,
  input  logic [FW-1:0] rbase_i,
  output logic [LW-1:0] phys_o,
  output logic          bad_o
);
  localparam int TW = FW + 1;

  logic [TW-1:0] idx, ridx, tsum, off;

  always_comb begin
    idx    = TW'(log_i) - TW'(FIX_REGS);
    ridx   = idx;
    tsum   = '0;
    off    = '0;
    phys_o = log_i;
    bad_o  = 1'b0;
    if (log_i >= LW'(FIX_REGS)) begin
      if (idx >= TW'(size_i)) begin
        bad_o  = 1'b1;
        phys_o = '0;
      end else begin
        if (idx < TW'(rsize_i)) begin
          tsum = idx + TW'(rbase_i);
          ridx = (tsum >= TW'(rsize_i)) ? tsum - TW'(rsize_i) : tsum;
        end
        off = TW'(base_i) + ridx;
        if (off >= TW'(STK_REGS)) off = off - TW'(STK_REGS);
        phys_o = LW'(off + TW'(FIX_REGS));
      end
    end
  end
endmodule

// File: rtl/remap_frame.sv
module remap_frame
  import remap_pkg::*;
#(
  parameter int STK_REGS = 96,
  parameter int DEPTH    = 8,
  parameter int CW       = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          alloc_i,
  input  logic [FW-1:0] alloc_size,
  input  logic [FW-1:0] alloc_locals,
  input  logic [FW-1:0] alloc_rot,
  input  logic          rotate_i,
  output marker_t       cur_o,
  output logic [CW-1:0] committed_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  marker_t        cur;
  marker_t        stk [DEPTH];
  logic [SPW-1:0] sp;
  logic [CW-1:0]  committed;

  logic          full, empty, alloc_ok;
  logic [IW-1:0] push_idx, pop_idx;
  logic [FW:0]   bsum;
  logic [FW-1:0] nbase;

  assign full     = (sp == SPW'(DEPTH));
  assign empty    = (sp == '0);
  assign push_idx = IW'(sp);
  assign pop_idx  = IW'(sp - 1'b1);
  assign alloc_ok = (alloc_size <= FW'(STK_REGS)) && (alloc_locals <= alloc_size)
                    && (alloc_rot <= alloc_size);
  assign bsum     = {1'b0, cur.base} + {1'b0, cur.locals};
  assign nbase    = (bsum >= (FW+1)'(STK_REGS)) ? FW'(bsum - (FW+1)'(STK_REGS)) : FW'(bsum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur       <= '0;
      sp        <= '0;
      committed <= '0;
    end else if (call_i) begin
      if (!full) begin
        cur.base   <= nbase;
        cur.size   <= cur.size - cur.locals;
        cur.locals <= '0;
        cur.rsize  <= '0;
        cur.rbase  <= '0;
        sp         <= sp + 1'b1;
        committed  <= committed + CW'(cur.locals);
      end
    end else if (ret_i) begin
      if (!empty) begin
        cur       <= stk[pop_idx];
        sp        <= sp - 1'b1;
        committed <= committed - CW'(stk[pop_idx].locals);
      end
    end else if (alloc_i) begin
      if (alloc_ok) begin
        cur.size   <= alloc_size;
        cur.locals <= alloc_locals;
        cur.rsize  <= alloc_rot;
        cur.rbase  <= '0;
      end
    end else if (rotate_i && cur.rsize != '0) begin
      cur.rbase <= (cur.rbase == '0) ? cur.rsize - 1'b1 : cur.rbase - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && call_i && !full) stk[push_idx] <= cur;
  end

  assign cur_o       = cur;
  assign committed_o = committed;
endmodule

// File: rtl/remap_top.sv
module remap_top
  import remap_pkg::*;
#(
  parameter int FIX_REGS = 32,
  parameter int STK_REGS = 96,
  parameter int DEPTH    = 8,
  parameter int LW       = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [LW-1:0] rd0_log,
  output logic [LW-1:0] rd0_phys,
  output logic          rd0_bad,
  input  logic [LW-1:0] rd1_log,
  output logic [LW-1:0] rd1_phys,
  output logic          rd1_bad,
  input  logic [LW-1:0] wr_log,
  output logic [LW-1:0] wr_phys,
  output logic          wr_bad,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          alloc_i,
  input  logic [FW-1:0] alloc_size,
  input  logic [FW-1:0] alloc_locals,
  input  logic [FW-1:0] alloc_rot,
  input  logic          rotate_i,
  output logic          overflow_o
);
  localparam int CW     = $clog2(STK_REGS * (DEPTH + 1) + 1);
  localparam int NPORTS = 3;

  marker_t       cur;
  logic [CW-1:0] committed;
  logic [LW-1:0] logs  [NPORTS];
  logic [LW-1:0] physs [NPORTS];
  logic          bads  [NPORTS];

  remap_frame #(.STK_REGS(STK_REGS), .DEPTH(DEPTH), .CW(CW)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .call_i       (call_i),
    .ret_i        (ret_i),
    .alloc_i      (alloc_i),
    .alloc_size   (alloc_size),
    .alloc_locals (alloc_locals),
    .alloc_rot    (alloc_rot),
    .rotate_i     (rotate_i),
    .cur_o        (cur),
    .committed_o  (committed)
  );

  assign logs[0] = rd0_log;
  assign logs[1] = rd1_log;
  assign logs[2] = wr_log;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    remap_xlate #(.FIX_REGS(FIX_REGS), .STK_REGS(STK_REGS), .LW(LW), .FW(FW)) u_xlate (
      .log_i   (logs[p]),
      .base_i  (cur.base),
      .size_i  (cur.size),
      .rsize_i (cur.rsize),
      .rbase_i (cur.rbase),
      .phys_o  (physs[p]),
      .bad_o   (bads[p])
    );
  end

  assign rd0_phys = physs[0];
  assign rd0_bad  = bads[0];
  assign rd1_phys = physs[1];
  assign rd1_bad  = bads[1];
  assign wr_phys  = physs[2];
  assign wr_bad   = bads[2];

  assign overflow_o = (committed + CW'(cur.size)) > CW'(STK_REGS);
endmodule

// File: rtl/remap_chk.sv
module remap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] rd0_log,
  input logic [6:0] rd0_phys,
  input logic       rd0_bad,
  input logic [6:0] rd1_log,
  input logic [6:0] rd1_phys,
  input logic       rd1_bad,
  input logic [6:0] wr_log,
  input logic [6:0] wr_phys,
  input logic       wr_bad,
  input logic       call_i,
  input logic       ret_i,
  input logic       alloc_i,
  input logic       rotate_i,
  input logic       overflow_o
);
  assert_fixed_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_log < 7'd32) |-> (rd0_phys == rd0_log && !rd0_bad));

  assert_stacked_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd1_log >= 7'd32 && !rd1_bad) |-> (rd1_phys >= 7'd32));

  assert_bad_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bad |-> (wr_phys == 7'd0 && wr_log >= 7'd32));

  assert_ovf_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(call_i || ret_i || alloc_i) |=> $stable(overflow_o));

  assert_ports_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0_log == wr_log) |-> (rd0_phys == wr_phys && rd0_bad == wr_bad));
endmodule

bind remap_top remap_chk i_remap_chk (.*);

// File: tb/test_remap_top.sv
module test_remap_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] rd0_log, rd1_log, wr_log;
  logic [6:0] rd0_phys, rd1_phys, wr_phys;
  logic       rd0_bad, rd1_bad, wr_bad;
  logic       call_i, ret_i, alloc_i, rotate_i;
  logic [6:0] alloc_size, alloc_locals, alloc_rot;
  logic       overflow_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  remap_top i_remap_top (.*);

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    report();
  end

  task automatic chk(input int port, input logic [6:0] lg, input logic [6:0] ep,
                     input logic eb, input string tag);
    logic [6:0] ap;
    logic       ab;
    if (port == 0) rd0_log = lg; else if (port == 1) rd1_log = lg; else wr_log = lg;
    #1;
    if (port == 0) begin ap = rd0_phys; ab = rd0_bad; end
    else if (port == 1) begin ap = rd1_phys; ab = rd1_bad; end
    else begin ap = wr_phys; ab = wr_bad; end
    checks++;
    if (ap !== ep || ab !== eb) begin
      fails++;
      $display("FAIL %s port%0d log=%0d: actual phys=%0d bad=%0b expected phys=%0d bad=%0b",
               tag, port, lg, ap, ab, ep, eb);
    end
  endtask

  task automatic chk_ovf(input logic e, input string tag);
    #1;
    checks++;
    if (overflow_o !== e) begin
      fails++;
      $display("FAIL %s overflow: actual=%0b expected=%0b", tag, overflow_o, e);
    end
  endtask

  task automatic ctl(input logic c, input logic r, input logic a, input logic ro,
                     input logic [6:0] s, input logic [6:0] l, input logic [6:0] rr);
    @(negedge clk);
    call_i = c; ret_i = r; alloc_i = a; rotate_i = ro;
    alloc_size = s; alloc_locals = l; alloc_rot = rr;
    @(negedge clk);
    call_i = 0; ret_i = 0; alloc_i = 0; rotate_i = 0;
  endtask

  task automatic alloc(input logic [6:0] s, input logic [6:0] l, input logic [6:0] rr);
    ctl(0, 0, 1, 0, s, l, rr);
  endtask
  task automatic do_call();   ctl(1, 0, 0, 0, 0, 0, 0); endtask
  task automatic do_ret();    ctl(0, 1, 0, 0, 0, 0, 0); endtask
  task automatic do_rotate(); ctl(0, 0, 0, 1, 0, 0, 0); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    call_i = 0; ret_i = 0; alloc_i = 0; rotate_i = 0;
    alloc_size = 0; alloc_locals = 0; alloc_rot = 0;
    rd0_log = 0; rd1_log = 0; wr_log = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(0, 7'd5, 7'd5, 0, "R9 reset low reg");
    chk(1, 7'd32, 7'd0, 1, "R9 reset empty frame");
    chk_ovf(0, "R9 reset");
  endtask

  task automatic t_fixed();
    do_reset();
    alloc(10, 6, 4);
    chk(0, 7'd0, 7'd0, 0, "R1 low edge");
    chk(1, 7'd31, 7'd31, 0, "R1 high edge");
    chk(2, 7'd17, 7'd17, 0, "R1 write port");
  endtask

  task automatic t_alloc_map();
    do_reset();
    alloc(10, 6, 0);
    chk(0, 7'd41, 7'd41, 0, "R2 last frame reg");
    chk(1, 7'd42, 7'd0, 1, "R3 past frame");
    alloc(10, 12, 0);
    chk(0, 7'd41, 7'd41, 0, "R4 bad locals ignored");
    alloc(97, 0, 0);
    chk(1, 7'd42, 7'd0, 1, "R4 oversize ignored");
    alloc(10, 2, 11);
    chk(2, 7'd33, 7'd33, 0, "R4 bad rot ignored");
  endtask

  task automatic t_call_ret();
    do_reset();
    alloc(10, 6, 0);
    do_call();
    chk(0, 7'd32, 7'd38, 0, "R6 callee base");
    chk(1, 7'd35, 7'd41, 0, "R6 callee top");
    chk(2, 7'd36, 7'd0, 1, "R6 callee size");
    chk_ovf(0, "R8 after call");
    do_ret();
    chk(0, 7'd41, 7'd41, 0, "R7 caller restored");
    chk(1, 7'd42, 7'd0, 1, "R7 caller size");
  endtask

  task automatic t_rotate();
    do_reset();
    alloc(10, 0, 0);
    do_rotate();
    chk(0, 7'd33, 7'd33, 0, "R5 no rot region");
    alloc(10, 6, 0);
    do_call();
    alloc(20, 20, 8);
    chk(0, 7'd32, 7'd38, 0, "R5 rot base 0");
    do_rotate();
    chk(0, 7'd32, 7'd45, 0, "R5 after one rotate");
    chk(1, 7'd39, 7'd44, 0, "R5 rot top");
    chk(2, 7'd40, 7'd46, 0, "R5 above rot region");
    do_rotate();
    chk(0, 7'd32, 7'd44, 0, "R5 after two rotates");
    do_call();
    do_ret();
    chk(1, 7'd32, 7'd44, 0, "R7 rot base restored");
    do_ret();
    do_call();
    alloc(20, 20, 8);
    chk(0, 7'd32, 7'd38, 0, "R6 rot base cleared");
  endtask

  task automatic t_wrap_ovf();
    do_reset();
    alloc(96, 90, 0);
    do_call();
    chk_ovf(0, "R8 exactly full");
    alloc(20, 20, 0);
    chk(0, 7'd32, 7'd122, 0, "R2 high base");
    chk(1, 7'd37, 7'd127, 0, "R2 top of file");
    chk(2, 7'd38, 7'd32, 0, "R2 wrap");
    chk_ovf(1, "R8 over");
    do_ret();
    chk_ovf(0, "R8 after return");
  endtask

  task automatic t_stack_limits();
    do_reset();
    alloc(10, 4, 0);
    do_ret();
    chk(0, 7'd41, 7'd41, 0, "R7 empty return ignored");
    do_call();
    for (int k = 0; k < 7; k++) begin
      alloc(2, 1, 0);
      do_call();
    end
    chk(0, 7'd32, 7'd43, 0, "R6 eighth frame");
    alloc(2, 1, 0);
    do_call();
    chk(1, 7'd33, 7'd44, 0, "R6 full stack ignored");
  endtask

  task automatic t_priority();
    do_reset();
    alloc(10, 6, 0);
    ctl(1, 0, 1, 1, 50, 0, 0);
    chk(0, 7'd35, 7'd41, 0, "R9 call wins");
    chk(1, 7'd36, 7'd0, 1, "R9 alloc blocked");
    ctl(0, 1, 1, 0, 50, 0, 0);
    chk(2, 7'd42, 7'd0, 1, "R9 return wins");
  endtask

  task automatic t_ports();
    do_reset();
    alloc(12, 12, 5);
    do_rotate();
    rd0_log = 7'd33;
    rd1_log = 7'd33;
    chk(2, 7'd33, 7'd32, 0, "R10 write port");
    chk(1, 7'd33, 7'd32, 0, "R10 read port 1");
    chk(0, 7'd33, 7'd32, 0, "R10 read port 0");
  endtask

  initial begin
    t_reset();
    t_fixed();
    t_alloc_map();
    t_call_ret();
    t_rotate();
    t_wrap_ovf();
    t_stack_limits();
    t_priority();
    t_ports();
    report();
  end
endmodule